// File: doc/BRIEF.md
# Two-Input Priority Merge

The block combines two token streams, each with its own valid/ready handshake, onto a single output channel. It carries no payload from its inputs. Instead, the output channel's data is an index that reports which input supplied the current token. Arbitration is fixed: input 0 is served whenever it offers a token, and input 1 is served only when input 0 is idle.

The whole path is combinational, so it adds no cycle of latency. When the output transfers, only the input that won is acknowledged. The loser keeps its token and waits. Under sustained traffic on input 0, input 1 is never served, and users must accept that starvation or break it upstream.

Top module: `merge_prio2`

## Requirements
- R1: `out_valid` is high exactly when at least one of `in0_valid` and `in1_valid` is high.
- R2: When `in0_valid` is high, `out_idx` equals 0, whatever the state of `in1_valid`.
- R3: When `in1_valid` is high and `in0_valid` is low, `out_idx` equals 1. The value is zero-extended to `IDX_W` bits, with bit 0 as the index and all upper bits 0.
- R4: `in0_ready` is high exactly when `in0_valid` and `out_ready` are both high.
- R5: `in1_ready` is high exactly when `in1_valid` and `out_ready` are high and `in0_valid` is low.
- R6: While `out_ready` is low, neither `in0_ready` nor `in1_ready` is asserted.
- R7: With neither input valid, `out_valid` is low and neither input ready is asserted. The value of `out_idx` is not specified in this state.
- R8: If both inputs are held valid and `out_ready` is held high over many cycles, every transfer is taken from input 0 and input 1 is never acknowledged.
- R9: Each output transfer acknowledges exactly one input, and `out_idx` names that input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in0_valid | input | 1 | Input 0 (high priority) offers a token |
| in0_ready | output | 1 | Input 0 token accepted this cycle |
| in1_valid | input | 1 | Input 1 (low priority) offers a token |
| in1_ready | output | 1 | Input 1 token accepted this cycle |
| out_valid | output | 1 | Merged token available |
| out_ready | input | 1 | Consumer accepts the merged token |
| out_idx | output | IDX_W | Index of the input that supplied the token |

## Verification
The bench builds two instances. The first uses the default `IDX_W` of 1, which exercises the plain one-bit index across all input combinations. The second uses `IDX_W` set to 3, which makes the zero padding of the upper index bits observable. Both instances see the same random and directed valid/ready patterns. A long run with both inputs held valid exercises the starvation case.

// File: rtl/merge_prio2_pkg.sv
package merge_prio2_pkg;
  // Input 0 takes the output whenever it offers a token.
  function automatic logic first_takes(input logic v0);
    return v0;
  endfunction

  // The index names input 1 whenever input 0 is not offering.
  function automatic logic second_named(input logic v0);
    return ~v0;
  endfunction

  function automatic logic any_offer(input logic v0, input logic v1);
    return v0 | v1;
  endfunction
endpackage

// File: rtl/merge_prio2_pick.sv
module merge_prio2_pick
  import merge_prio2_pkg::*;
(
  input  logic v0,
  input  logic v1,
  output logic any_valid,
  output logic take_first,
  output logic take_second
);
  assign any_valid   = any_offer(v0, v1);
  assign take_first  = first_takes(v0);
  assign take_second = second_named(v0);
endmodule

// File: rtl/merge_prio2_steer.sv
module merge_prio2_steer (
  input  logic any_valid,
  input  logic take_first,
  input  logic take_second,
  input  logic sink_ready,
  output logic xfer,
  output logic ack0,
  output logic ack1
);
  assign xfer = any_valid & sink_ready;
  assign ack0 = xfer & take_first;
  assign ack1 = xfer & take_second;
endmodule

// File: rtl/merge_prio2_idx.sv
module merge_prio2_idx #(
  parameter int IDX_W = 1
) (
  input  logic             take_second,
  output logic [IDX_W-1:0] idx
);
  localparam int PAD_W = IDX_W - 1;
  generate
    if (PAD_W == 0) begin : g_narrow
      assign idx = take_second;
    end else begin : g_wide
      assign idx = {{PAD_W{1'b0}}, take_second};
    end
  endgenerate
endmodule

// File: rtl/merge_prio2.sv
module merge_prio2 #(
  parameter int IDX_W = 1
) (
  input  logic             in0_valid,
  output logic             in0_ready,
  input  logic             in1_valid,
  output logic             in1_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] out_idx
);
  logic any_valid;
  logic take_first;
  logic take_second;
  logic xfer;

  merge_prio2_pick u_pick (
    .v0(in0_valid), .v1(in1_valid),
    .any_valid(any_valid), .take_first(take_first), .take_second(take_second)
  );

  merge_prio2_steer u_steer (
    .any_valid(any_valid), .take_first(take_first), .take_second(take_second),
    .sink_ready(out_ready), .xfer(xfer), .ack0(in0_ready), .ack1(in1_ready)
  );

  merge_prio2_idx #(.IDX_W(IDX_W)) u_idx (
    .take_second(take_second), .idx(out_idx)
  );

  assign out_valid = any_valid;

  // Named transfer event, unused beyond observation.
  logic xfer_seen;
  assign xfer_seen = xfer;
endmodule

// File: rtl/merge_prio2_chk.sv
module merge_prio2_chk #(
  parameter int IDX_W = 1
) (
  input logic             in0_valid,
  input logic             in0_ready,
  input logic             in1_valid,
  input logic             in1_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_idx
);
  always_comb begin
    // R9: never both acknowledged
    assert_single_ack_R9: assert ($onehot0({in0_ready, in1_ready}));
    // R6: an acknowledge only during an output transfer
    if (in0_ready || in1_ready)
      assert_ack_on_xfer_R6: assert (out_valid && out_ready);
    // R2: first input wins
    if (in0_valid)
      assert_first_idx_R2: assert (out_idx == '0);
    // R9: index matches acknowledged input 1
    if (in1_ready)
      assert_idx_match_R9: assert (out_idx == IDX_W'(1));
    // R7: idle means no output
    if (!in0_valid && !in1_valid)
      assert_idle_quiet_R7: assert (!out_valid && !in0_ready && !in1_ready);
  end
endmodule

bind merge_prio2 merge_prio2_chk #(.IDX_W(IDX_W)) u_chk (
  .in0_valid(in0_valid), .in0_ready(in0_ready),
  .in1_valid(in1_valid), .in1_ready(in1_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx)
);

// File: tb/tb_merge_prio2.sv
module tb_merge_prio2;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic v0, v1, ordy;
  logic r0_a, r1_a, ov_a;
  logic [0:0] idx_a;
  logic r0_b, r1_b, ov_b;
  logic [2:0] idx_b;
  int checks = 0;
  int errors = 0;
  int acks1 = 0;
  bit done = 0;

  merge_prio2 #(.IDX_W(1)) dut (
    .in0_valid(v0), .in0_ready(r0_a), .in1_valid(v1), .in1_ready(r1_a),
    .out_valid(ov_a), .out_ready(ordy), .out_idx(idx_a));
  merge_prio2 #(.IDX_W(3)) dut_w3 (
    .in0_valid(v0), .in0_ready(r0_b), .in1_valid(v1), .in1_ready(r1_b),
    .out_valid(ov_b), .out_ready(ordy), .out_idx(idx_b));

  function automatic logic e_valid(logic a, logic b); return a || b; endfunction
  function automatic logic e_r0(logic a, logic r); return a && r; endfunction
  function automatic logic e_r1(logic a, logic b, logic r); return b && r && !a; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic eval_all();
    logic ev, e0, e1;
    ev = e_valid(v0, v1); e0 = e_r0(v0, ordy); e1 = e_r1(v0, v1, ordy);
    chk(ov_a == ev, "R1", ov_a, ev);
    chk(ov_b == ev, "R1", ov_b, ev);
    chk(r0_a == e0 && r0_b == e0, "R4", r0_a, e0);
    chk(r1_a == e1 && r1_b == e1, "R5", r1_a, e1);
    if (v0) begin
      chk(idx_a == 1'b0, "R2", idx_a, 0);
      chk(idx_b == 3'd0, "R2", idx_b, 0);
    end else if (v1) begin
      chk(idx_a == 1'b1, "R3", idx_a, 1);
      chk(idx_b == 3'd1, "R3", idx_b, 1);
    end
    if (!ordy) chk(!r0_a && !r1_a, "R6", {r0_a, r1_a}, 0);
    if (!v0 && !v1) chk(!ov_a && !r0_a && !r1_a, "R7", {ov_a, r0_a, r1_a}, 0);
    if (ov_a && ordy) begin
      chk((r0_a ^ r1_a) == 1'b1, "R9", {r0_a, r1_a}, 1);
      chk(idx_a == r1_a, "R9", idx_a, r1_a);
    end
  endtask

  task automatic apply(input logic a, input logic b, input logic r);
    @(negedge clk);
    v0 = a; v1 = b; ordy = r;
    #1;
    eval_all();
  endtask

  initial begin
    int seed;
    v0 = 0; v1 = 0; ordy = 0;
    seed = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    chk(!ov_a && !r0_a && !r1_a, "R7", {ov_a, r0_a, r1_a}, 0);
    for (int i = 0; i < 8; i++) apply(i[0], i[1], i[2]);
    for (int i = 0; i < 400; i++)
      apply(1'($urandom), 1'($urandom), 1'($urandom));
    // R8: sustained contention starves input 1
    for (int i = 0; i < 50; i++) begin
      apply(1'b1, 1'b1, 1'b1);
      if (r1_a) acks1++;
      chk(r0_a == 1'b1, "R8", r0_a, 1);
    end
    chk(acks1 == 0, "R8", acks1, 0);
    apply(1'b0, 1'b1, 1'b1);
    chk(r1_a == 1'b1 && idx_a == 1'b1, "R8", r1_a, 1);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule